// File: doc/BRIEF.md
# First and Next Error Logger

This block records error events from several interface sources into two status registers and raises a system-error pulse. Each source delivers a one-cycle event pulse; bus-side sources also present the address and data of the failing cycle alongside the pulse. When the first-error register is empty, the lowest-numbered incoming event is recorded there as a single bit. Every other event, whether it arrives in the same cycle or later, is ORed into the next-error register.

The first time a bus-side error is logged while the first-error register is empty, the address and data qualifiers are stored. Those two capture registers then stay frozen until software empties the first-error register. Software clears either status register through a write-one-to-clear port that uses one select bit. Errors that raise a system error and arrive close together are merged into one pulse by a short holdoff window.

Top module: `err_logger`

## Requirements
- R1: After synchronous reset, both status registers, both capture registers and `serr_o` are zero.
- R2: The first-error register never has more than one bit set. It loads only on an edge where it is all zero and at least one event is present. It then takes the bit of the lowest-numbered event, and otherwise it changes only when software clears it.
- R3: When several events arrive together while the first-error register is empty, every event other than the lowest-numbered one is set in the next-error register in that same cycle.
- R4: When the first-error register is non-zero, each incoming event sets its bit in the next-error register, and no bit already set there is lost unless software clears it.
- R5: A write with `csr_wr_i` high clears the bits given as ones in `csr_wdata_i`. `csr_sel_i` = 0 selects the first-error register and `csr_sel_i` = 1 selects the next-error register. On the next-error register, an event arriving in the same cycle as a clear of its bit leaves the bit set.
- R6: Sources 0, 1 and 2 are bus-side. An event from any of them on an edge where the first-error register is empty loads `pci_addr_i` and `pci_data_i` into the capture registers.
- R7: While the first-error register is non-zero, the capture registers hold their value. This applies even when the logged first error came from a source that is not bus-side.
- R8: Events from sources 0, 1, 3 and 5 request a system error. A request with no holdoff active drives `serr_o` high for exactly one cycle, in the cycle after the event.
- R9: Requests made during the 4 cycles that follow a `serr_o` pulse are merged into that pulse and produce no new pulse. The first request after that window produces a new pulse.
- R10: Events from sources 2 and 4 are logged but never drive `serr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 6 | One-cycle error event pulses, one bit per source |
| pci_addr_i | input | 32 | Address of the failing bus cycle, valid with a bus-side event |
| pci_data_i | input | 32 | Data of the failing bus cycle, valid with a bus-side event |
| csr_wr_i | input | 1 | Write-one-to-clear strobe |
| csr_sel_i | input | 1 | 0 selects the first-error register, 1 the next-error register |
| csr_wdata_i | input | 6 | Bits to clear |
| first_err_o | output | 6 | First-error register |
| next_err_o | output | 6 | Next-error register |
| cap_addr_o | output | 32 | Captured failing address |
| cap_data_o | output | 32 | Captured failing data |
| serr_o | output | 1 | One-cycle system-error pulse |

## Verification
The assertions assume that event inputs are zero during reset and carry no unknown values. Under that assumption, a `$past` of the request taken at the first edge after reset is well defined. The register-stability properties take the absence of a clear strobe as the only thing that could empty a register, so the stimulus never pulses `rst` outside the opening sequence. The bench changes inputs only at falling edges and keeps them stable across each rising edge. It idles at least six cycles between scenarios, so that one scenario's holdoff never reaches into the next.

// File: rtl/err_log_pkg.sv
package err_log_pkg;

    localparam int ERR_SRC_N   = 6;
    localparam int ERR_ADDR_W  = 32;
    localparam int ERR_DATA_W  = 32;
    localparam int ERR_HOLDOFF = 4;

    typedef enum logic {
        CSR_FIRST = 1'b0,
        CSR_NEXT  = 1'b1
    } csr_sel_e;

    typedef struct packed {
        logic [ERR_ADDR_W-1:0] addr;
        logic [ERR_DATA_W-1:0] data;
    } cap_t;

    function automatic int unsigned cnt_width(input int unsigned maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction

endpackage

// File: rtl/err_status_regs.sv
module err_status_regs #(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt,
    input  logic [NUM_SRC-1:0] clr_first,
    input  logic [NUM_SRC-1:0] clr_next,
    output logic [NUM_SRC-1:0] first_q,
    output logic [NUM_SRC-1:0] next_q,
    output logic               first_empty
);
    localparam logic [NUM_SRC-1:0] ONE = NUM_SRC'(1);

    logic [NUM_SRC-1:0] lowest;
    logic [NUM_SRC-1:0] load_bits;
    logic [NUM_SRC-1:0] spill_bits;

    always_comb begin
        first_empty = (first_q == '0);
        lowest      = evt & (~evt + ONE);
        load_bits   = first_empty ? lowest : '0;
        spill_bits  = first_empty ? (evt & ~lowest) : evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= '0;
            next_q  <= '0;
        end else begin
            first_q <= (first_q & ~clr_first) | load_bits;
            next_q  <= (next_q & ~clr_next) | spill_bits;
        end
    end

    // R2: at most one bit recorded as first error
    a_r2_first_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(first_q));

    // R2: a held first error only changes through a clear
    a_r2_first_held: assert property (@(posedge clk) disable iff (rst)
        (first_q != '0 && clr_first == '0) |=> $stable(first_q));

    // R4: next-error bits are not lost without a clear
    a_r4_next_sticky: assert property (@(posedge clk) disable iff (rst)
        (clr_next == '0) |=> ((next_q & $past(next_q)) == $past(next_q)));

    // R3: simultaneous events on an empty register spill into next-error
    a_r3_spill: assert property (@(posedge clk) disable iff (rst)
        (first_empty && $countones(evt) > 1) |=> (next_q != '0));

endmodule

// File: rtl/err_capture.sv
module err_capture
    import err_log_pkg::*;
#(
    parameter int                 NUM_SRC  = 6,
    parameter logic [NUM_SRC-1:0] PCI_MASK = 6'b000111
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_SRC-1:0]    evt,
    input  logic                  open_win,
    input  logic [ERR_ADDR_W-1:0] addr_in,
    input  logic [ERR_DATA_W-1:0] data_in,
    output cap_t                  cap_q
);
    logic bus_hit;

    always_comb bus_hit = |(evt & PCI_MASK);

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else if (open_win && bus_hit) begin
            cap_q.addr <= addr_in;
            cap_q.data <= data_in;
        end
    end

    // R7: capture frozen while a first error is held
    a_r7_frozen: assert property (@(posedge clk) disable iff (rst)
        !open_win |=> $stable(cap_q));

    // R6: a bus-side event on an open window is stored
    a_r6_capture: assert property (@(posedge clk) disable iff (rst)
        (open_win && bus_hit) |=> (cap_q.addr == $past(addr_in) && cap_q.data == $past(data_in)));

endmodule

// File: rtl/err_serr_pulse.sv
module err_serr_pulse
    import err_log_pkg::*;
#(
    parameter int HOLDOFF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic serr
);
    localparam int CW = cnt_width(HOLDOFF + 1);

    logic [CW-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            serr   <= 1'b0;
            hold_q <= '0;
        end else if (req && hold_q == '0) begin
            serr   <= 1'b1;
            hold_q <= CW'(HOLDOFF);
        end else begin
            serr   <= 1'b0;
            hold_q <= (hold_q != '0) ? hold_q - 1'b1 : hold_q;
        end
    end

    // checker: cycles since the last pulse, counted independently
    logic [CW-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (rst)
            gap_q <= CW'(HOLDOFF + 1);
        else if (serr)
            gap_q <= CW'(1);
        else if (gap_q <= CW'(HOLDOFF))
            gap_q <= gap_q + 1'b1;
    end

    // R8: pulse lasts one cycle
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
        serr |=> !serr);

    // R8: pulse only follows a request
    a_r8_caused: assert property (@(posedge clk) disable iff (rst)
        serr |-> $past(req));

    // R9: pulses are separated by more than the holdoff
    a_r9_holdoff: assert property (@(posedge clk) disable iff (rst)
        serr |-> (gap_q > CW'(HOLDOFF)));

endmodule

// File: rtl/err_logger.sv
module err_logger
    import err_log_pkg::*;
#(
    parameter int                 NUM_SRC   = ERR_SRC_N,
    parameter logic [NUM_SRC-1:0] PCI_MASK  = 6'b000111,
    parameter logic [NUM_SRC-1:0] SERR_MASK = 6'b101011,
    parameter int                 HOLDOFF   = ERR_HOLDOFF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_SRC-1:0]    evt_i,
    input  logic [ERR_ADDR_W-1:0] pci_addr_i,
    input  logic [ERR_DATA_W-1:0] pci_data_i,
    input  logic                  csr_wr_i,
    input  logic                  csr_sel_i,
    input  logic [NUM_SRC-1:0]    csr_wdata_i,
    output logic [NUM_SRC-1:0]    first_err_o,
    output logic [NUM_SRC-1:0]    next_err_o,
    output logic [ERR_ADDR_W-1:0] cap_addr_o,
    output logic [ERR_DATA_W-1:0] cap_data_o,
    output logic                  serr_o
);
    csr_sel_e           sel;
    logic [NUM_SRC-1:0] clr_first;
    logic [NUM_SRC-1:0] clr_next;
    logic               first_empty;
    logic               serr_req;
    cap_t               cap;

    always_comb begin
        sel       = csr_sel_e'(csr_sel_i);
        clr_first = (csr_wr_i && sel == CSR_FIRST) ? csr_wdata_i : '0;
        clr_next  = (csr_wr_i && sel == CSR_NEXT)  ? csr_wdata_i : '0;
        serr_req  = |(evt_i & SERR_MASK);
    end

    err_status_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt_i),
        .clr_first   (clr_first),
        .clr_next    (clr_next),
        .first_q     (first_err_o),
        .next_q      (next_err_o),
        .first_empty (first_empty)
    );

    err_capture #(.NUM_SRC(NUM_SRC), .PCI_MASK(PCI_MASK)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_i),
        .open_win (first_empty),
        .addr_in  (pci_addr_i),
        .data_in  (pci_data_i),
        .cap_q    (cap)
    );

    err_serr_pulse #(.HOLDOFF(HOLDOFF)) u_serr (
        .clk  (clk),
        .rst  (rst),
        .req  (serr_req),
        .serr (serr_o)
    );

    always_comb begin
        cap_addr_o = cap.addr;
        cap_data_o = cap.data;
    end

    // R10: a cycle with only non-requesting sources gives no pulse
    a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
        ((evt_i & SERR_MASK) == '0) |=> !serr_o);

endmodule

// File: tb/test_err_logger.sv
`timescale 1ns/1ps
module test_err_logger;
    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  evt;
    logic [31:0] addr, data;
    logic        wr, sel;
    logic [5:0]  wdata;
    logic [5:0]  first_err, next_err;
    logic [31:0] cap_addr, cap_data;
    logic        serr;

    int vectors = 0;
    int miscompares = 0;

    always #10 clk = ~clk;

    err_logger i_err_logger (
        .clk(clk), .rst(rst), .evt_i(evt), .pci_addr_i(addr), .pci_data_i(data),
        .csr_wr_i(wr), .csr_sel_i(sel), .csr_wdata_i(wdata),
        .first_err_o(first_err), .next_err_o(next_err),
        .cap_addr_o(cap_addr), .cap_data_o(cap_data), .serr_o(serr)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive for one edge, return at the following falling edge with inputs held
    task automatic drive(input logic [5:0] e, input logic [31:0] a, input logic [31:0] d,
                         input logic w, input logic s, input logic [5:0] wd);
        evt = e; addr = a; data = d; wr = w; sel = s; wdata = wd;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        evt = '0; addr = '0; data = '0; wr = 1'b0; sel = 1'b0; wdata = '0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_all();
        drive(6'b0, 0, 0, 1'b1, 1'b0, 6'h3f);
        drive(6'b0, 0, 0, 1'b1, 1'b1, 6'h3f);
        idle(1);
    endtask

    task automatic t_reset();
        chk("R1 first", first_err, 0);
        chk("R1 next", next_err, 0);
        chk("R1 addr", cap_addr, 0);
        chk("R1 data", cap_data, 0);
        chk("R1 serr", serr, 0);
    endtask

    task automatic t_single_and_later();
        drive(6'b000001, 32'hA000_0010, 32'hD000_0001, 0, 0, 0);
        chk("R2 first load", first_err, 6'b000001);
        chk("R6 addr", cap_addr, 32'hA000_0010);
        chk("R6 data", cap_data, 32'hD000_0001);
        chk("R8 pulse", serr, 1);
        idle(1);
        chk("R8 one cycle", serr, 0);
        idle(5);
        drive(6'b001000, 32'hA000_0020, 32'hD000_0002, 0, 0, 0);
        chk("R4 next set", next_err, 6'b001000);
        chk("R2 first held", first_err, 6'b000001);
        chk("R7 addr frozen", cap_addr, 32'hA000_0010);
        idle(6);
        clear_all();
        chk("R5 first cleared", first_err, 0);
        chk("R5 next cleared", next_err, 0);
    endtask

    task automatic t_same_cycle();
        drive(6'b010100, 32'hA000_0030, 32'hD000_0003, 0, 0, 0);
        chk("R3 first lowest", first_err, 6'b000100);
        chk("R3 spill", next_err, 6'b010000);
        chk("R6 addr src2", cap_addr, 32'hA000_0030);
        chk("R10 no pulse", serr, 0);
        idle(6);
        clear_all();
    endtask

    task automatic t_nonbus_first();
        drive(6'b010000, 32'hA000_0040, 32'hD000_0004, 0, 0, 0);
        chk("R2 first src4", first_err, 6'b010000);
        chk("R7 no capture src4", cap_addr, 32'hA000_0030);
        chk("R10 src4 no pulse", serr, 0);
        idle(2);
        drive(6'b000010, 32'hA000_0050, 32'hD000_0005, 0, 0, 0);
        chk("R4 next src1", next_err, 6'b000010);
        chk("R7 frozen data", cap_data, 32'hD000_0003);
        chk("R8 src1 pulse", serr, 1);
        idle(6);
        // clear next bits 5 and 1 while source 5 fires
        drive(6'b100000, 0, 0, 1, 1, 6'b100010);
        chk("R5 set wins", next_err, 6'b100000);
        idle(6);
        drive(6'b000000, 0, 0, 1, 0, 6'b010000);
        chk("R5 first w1c", first_err, 0);
        idle(1);
        drive(6'b000001, 32'hA000_0060, 32'hD000_0006, 0, 0, 0);
        chk("R6 recapture", cap_addr, 32'hA000_0060);
        chk("R2 reload", first_err, 6'b000001);
        idle(6);
        clear_all();
    endtask

    task automatic t_holdoff();
        drive(6'b000001, 0, 0, 0, 0, 0);
        chk("R9 first pulse", serr, 1);
        for (int i = 0; i < 4; i++) begin
            drive(6'b001000, 0, 0, 0, 0, 0);
            chk("R9 merged", serr, 0);
        end
        drive(6'b001000, 0, 0, 0, 0, 0);
        chk("R9 new pulse", serr, 1);
        idle(1);
        chk("R8 ends", serr, 0);
        idle(6);
    endtask

    initial begin
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_single_and_later();
        t_same_cycle();
        t_nonbus_first();
        t_holdoff();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule